// File: doc/BRIEF.md
# Static Memory Access Sequencer

This block turns a stream of single read and write requests into strobe sequences on an external asynchronous memory bus. Every access is timed by a small set of counts kept per chip select: when each active-low strobe (write enable, read enable, chip select) goes low and for how many clocks, and how long the whole cycle lasts. Any clocks left in a cycle after a strobe's setup and pulse form that strobe's hold time. A per-chip-select mode bit decides whether the write enable or the chip select frames the end of a write.

Between accesses the block may add one idle clock. A change of chip select always earns one turnaround clock. A read that follows a write to the same device earns one early-read clock when the write ends with no hold and the read starts with no setup. Which strobes count depends on the mode: in chip-select write mode the chip-select pair decides; in write-enable mode a sampled copy of the write-enable pin decides whether the write has really finished. The two kinds of extra clock are never added together.

Requests use a valid/ready handshake. Read data returns with a one-clock response strobe. Timing words are loaded through a write port that addresses one chip select at a time.

Top module: `static_mem_seq`

## Requirements
- R1: `req_ready` is high only while no access or turnaround is in progress. A request accepted with no turnaround keeps `req_ready` low for exactly the cycle length of its direction (write or read cycle field).
- R2: Counting the first access clock as 0, the write strobe (writes only) or read strobe (reads only) is low on clocks k with setup <= k < setup + pulse of that strobe. The two are never low together.
- R3: Chip select line i is low only for an access to chip select i, on the clocks inside the write or read chip-select window. Byte selects equal the inverted request byte enables during the access.
- R4: Read data is captured on the clock edge at which the read strobe rises, and is presented on `rsp_rdata` with `rsp_valid` high for exactly one clock.
- R5: An access whose chip select differs from the previous access gets exactly one extra idle clock. During it all strobes and chip selects are high and the data bus is released. No early-read clock is added on top of it.
- R6: A read to the same chip select as a preceding write gets one early-read clock when the write strobe's setup plus pulse reaches the write cycle length and the read strobe setup is 0.
- R7: With mode bit 0 (chip select controls the write), that read also gets one early-read clock when the chip-select write setup plus pulse reaches the write cycle length and the chip-select read setup is 0, whatever the read strobe timing.
- R8: With mode bit 1 (write enable controls the write) and no write-strobe hold, that read gets one early-read clock if `mem_nwe_fb` is still low when the read is accepted, and none if it is high (with the read setup nonzero).
- R9: During an early-read clock the address, the driven write data (`mem_doe` high) and the byte selects keep the values of the preceding write. All chip selects and strobes are high.
- R10: No extra clock is added for a read after a read, a write after either, or a same-device read after a write that meets none of the R6 to R8 conditions.
- R11: `cfg_we` stores `cfg_word` for chip select `cfg_sel`. The 61-bit word, MSB first, is: mode bit [60], write cycle [59:54], read cycle [53:48], write-strobe setup [47:42] and pulse [41:36], read-strobe setup [35:30] and pulse [29:24], chip-select write setup [23:18] and pulse [17:12], chip-select read setup [11:6] and pulse [5:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Timing word write strobe |
| cfg_sel | input | SEL_W | Chip select whose timing is written |
| cfg_word | input | 61 | Timing word (layout in R11) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_cs | input | SEL_W | Target chip select |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| req_be | input | DW/8 | Byte enables, active high |
| rsp_valid | output | 1 | Read data valid, one clock |
| rsp_rdata | output | DW | Read data |
| mem_addr | output | AW | External address |
| mem_dout | output | DW | External write data |
| mem_doe | output | 1 | Data bus drive enable |
| mem_din | input | DW | External read data |
| mem_nwe_n | output | 1 | Write strobe, active low |
| mem_nrd_n | output | 1 | Read strobe, active low |
| mem_ncs_n | output | NUM_CS | Chip selects, active low |
| mem_nbs_n | output | DW/8 | Byte selects, active low |
| mem_nwe_fb | input | 1 | Sampled level of the write strobe pin |

## Verification
The hardest case to reach is the feedback rule: the write-enable pin must look still low when the following read is accepted, which a plain loopback never shows. The bench feeds `mem_nwe_fb` through a switchable one-clock delay and issues each read on the first clock `req_ready` returns, so the late-release case and the clean case both occur on the same chip select. Chip select timings are chosen so that each early-read rule alone triggers on its own device. A write on one device followed by a read on another device that would qualify shows that the two extra clocks are never stacked.

// File: rtl/smseq_pkg.sv
package smseq_pkg;

  parameter int unsigned CNT_W = 6;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    cnt_t setup;
    cnt_t pulse;
  } strobe_t;

  typedef struct packed {
    logic    wr_by_nwe;
    cnt_t    wr_cycle;
    cnt_t    rd_cycle;
    strobe_t nwe;
    strobe_t nrd;
    strobe_t ncs_wr;
    strobe_t ncs_rd;
  } cs_timing_t;

  localparam int unsigned TIMING_W = $bits(cs_timing_t);

  typedef enum logic [1:0] {TURN_NONE, TURN_CS, TURN_EARLY} turn_e;
  typedef enum logic [1:0] {ST_IDLE, ST_TURN, ST_ACC} seq_st_e;

  function automatic logic [CNT_W:0] strobe_end(strobe_t s);
    return {1'b0, s.setup} + {1'b0, s.pulse};
  endfunction

  function automatic logic zero_hold(strobe_t s, cnt_t cyc);
    return strobe_end(s) >= {1'b0, cyc};
  endfunction

  function automatic logic in_window(strobe_t s, cnt_t k);
    return ({1'b0, k} >= {1'b0, s.setup}) && ({1'b0, k} < strobe_end(s));
  endfunction

endpackage

// File: rtl/smseq_cfg_bank.sv
module smseq_cfg_bank
  import smseq_pkg::*;
#(
  parameter int unsigned NUM_CS = 4,
  parameter int unsigned SEL_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  cs_timing_t       wr_word,
  input  logic [SEL_W-1:0] rd_sel,
  output cs_timing_t       rd_word
);

  localparam cs_timing_t BANK_RST = '{
    wr_by_nwe: 1'b0,
    wr_cycle:  cnt_t'(1),
    rd_cycle:  cnt_t'(1),
    nwe:       '{setup: cnt_t'(0), pulse: cnt_t'(1)},
    nrd:       '{setup: cnt_t'(0), pulse: cnt_t'(1)},
    ncs_wr:    '{setup: cnt_t'(0), pulse: cnt_t'(1)},
    ncs_rd:    '{setup: cnt_t'(0), pulse: cnt_t'(1)}
  };

  cs_timing_t bank_q [NUM_CS];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_en && (wr_sel == SEL_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_q[g] <= BANK_RST;
      end else if (slot_en) begin
        bank_q[g] <= wr_word;
      end
    end
  end

  always_comb begin
    rd_word = bank_q[0];
    for (int i = 1; i < NUM_CS; i++) begin
      if (rd_sel == SEL_W'(i)) rd_word = bank_q[i];
    end
  end

endmodule

// File: rtl/smseq_turn.sv
module smseq_turn
  import smseq_pkg::*;
#(
  parameter int unsigned NUM_CS = 4,
  parameter int unsigned SEL_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             req_wr,
  input  logic [SEL_W-1:0] req_cs,
  input  cs_timing_t       tmg,
  input  logic             nwe_fb,
  output turn_e            kind
);

  logic             prev_vld_q, prev_vld_d;
  logic             prev_wr_q,  prev_wr_d;
  logic [SEL_W-1:0] prev_cs_q,  prev_cs_d;

  logic same_dev, wr_then_rd;
  logic rule_strobe, rule_ncs, rule_fb;

  always_comb begin
    same_dev   = prev_vld_q && (prev_cs_q == req_cs);
    wr_then_rd = same_dev && prev_wr_q && !req_wr;

    rule_strobe = zero_hold(tmg.nwe, tmg.wr_cycle) && (tmg.nrd.setup == '0);
    rule_ncs    = !tmg.wr_by_nwe && zero_hold(tmg.ncs_wr, tmg.wr_cycle) &&
                  (tmg.ncs_rd.setup == '0);
    rule_fb     = tmg.wr_by_nwe && zero_hold(tmg.nwe, tmg.wr_cycle) && !nwe_fb;

    if (prev_vld_q && !same_dev) begin
      kind = TURN_CS;
    end else if (wr_then_rd && (rule_strobe || rule_ncs || rule_fb)) begin
      kind = TURN_EARLY;
    end else begin
      kind = TURN_NONE;
    end
  end

  always_comb begin
    prev_vld_d = prev_vld_q;
    prev_wr_d  = prev_wr_q;
    prev_cs_d  = prev_cs_q;
    if (accept) begin
      prev_vld_d = 1'b1;
      prev_wr_d  = req_wr;
      prev_cs_d  = req_cs;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_vld_q <= 1'b0;
      prev_wr_q  <= 1'b0;
      prev_cs_q  <= '0;
    end else begin
      prev_vld_q <= prev_vld_d;
      prev_wr_q  <= prev_wr_d;
      prev_cs_q  <= prev_cs_d;
    end
  end

  p_early_wr_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == TURN_EARLY) |-> (prev_wr_q && !req_wr && prev_cs_q == req_cs));

  p_cs_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && prev_vld_q && prev_cs_q != req_cs) |-> (kind == TURN_CS));

endmodule

// File: rtl/smseq_engine.sv
module smseq_engine
  import smseq_pkg::*;
#(
  parameter int unsigned NUM_CS = 4,
  parameter int unsigned SEL_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  parameter int unsigned AW     = 24,
  parameter int unsigned DW     = 16,
  parameter int unsigned BW     = DW / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  output logic              accept,
  input  logic              req_wr,
  input  logic [SEL_W-1:0]  req_cs,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [BW-1:0]     req_be,
  input  cs_timing_t        req_tmg,
  input  turn_e             turn_kind,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_dout,
  output logic              mem_doe,
  input  logic [DW-1:0]     mem_din,
  output logic              mem_nwe_n,
  output logic              mem_nrd_n,
  output logic [NUM_CS-1:0] mem_ncs_n,
  output logic [BW-1:0]     mem_nbs_n
);

  seq_st_e          st_q,       st_d;
  cnt_t             cnt_q,      cnt_d;
  logic             cur_wr_q,   cur_wr_d;
  logic [SEL_W-1:0] cur_cs_q,   cur_cs_d;
  cs_timing_t       cur_t_q,    cur_t_d;
  logic [AW-1:0]    cur_addr_q, cur_addr_d;
  logic [DW-1:0]    cur_wd_q,   cur_wd_d;
  logic [BW-1:0]    cur_be_q,   cur_be_d;
  logic             early_q,    early_d;
  logic [AW-1:0]    bus_addr_q, bus_addr_d;
  logic [DW-1:0]    bus_wd_q,   bus_wd_d;
  logic [BW-1:0]    bus_be_q,   bus_be_d;
  logic             rsp_vld_q,  rsp_vld_d;
  logic [DW-1:0]    rdata_q,    rdata_d;

  logic             in_acc, in_turn, last_clk, capture, ncs_on, hold_bus;
  cnt_t             cyc_len;
  logic [CNT_W:0]   rd_end;

  // ---------------- next state ----------------
  always_comb begin
    in_acc   = (st_q == ST_ACC);
    in_turn  = (st_q == ST_TURN);
    accept   = req_valid && (st_q == ST_IDLE);
    cyc_len  = cur_wr_q ? cur_t_q.wr_cycle : cur_t_q.rd_cycle;
    last_clk = ({1'b0, cnt_q} + 1'b1) >= {1'b0, cyc_len};
    rd_end   = strobe_end(cur_t_q.nrd);
    capture  = in_acc && !cur_wr_q &&
               ((({1'b0, cnt_q} + 1'b1) == rd_end) ||
                (last_clk && (rd_end > {1'b0, cyc_len})));

    st_d       = st_q;
    cnt_d      = cnt_q;
    cur_wr_d   = cur_wr_q;
    cur_cs_d   = cur_cs_q;
    cur_t_d    = cur_t_q;
    cur_addr_d = cur_addr_q;
    cur_wd_d   = cur_wd_q;
    cur_be_d   = cur_be_q;
    early_d    = early_q;
    bus_addr_d = bus_addr_q;
    bus_wd_d   = bus_wd_q;
    bus_be_d   = bus_be_q;

    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          cur_wr_d   = req_wr;
          cur_cs_d   = req_cs;
          cur_t_d    = req_tmg;
          cur_addr_d = req_addr;
          cur_wd_d   = req_wdata;
          cur_be_d   = req_be;
          cnt_d      = '0;
          early_d    = (turn_kind == TURN_EARLY);
          if (turn_kind != TURN_NONE) begin
            st_d = ST_TURN;
          end else begin
            st_d       = ST_ACC;
            bus_addr_d = req_addr;
            bus_wd_d   = req_wdata;
            bus_be_d   = req_be;
          end
        end
      end
      ST_TURN: begin
        st_d       = ST_ACC;
        early_d    = 1'b0;
        bus_addr_d = cur_addr_q;
        bus_wd_d   = cur_wd_q;
        bus_be_d   = cur_be_q;
      end
      ST_ACC: begin
        if (last_clk) st_d = ST_IDLE;
        else          cnt_d = cnt_q + 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase

    rsp_vld_d = capture;
    rdata_d   = capture ? mem_din : rdata_q;
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      cur_wr_q   <= 1'b0;
      cur_cs_q   <= '0;
      cur_t_q    <= '0;
      cur_addr_q <= '0;
      cur_wd_q   <= '0;
      cur_be_q   <= '0;
      early_q    <= 1'b0;
      bus_addr_q <= '0;
      bus_wd_q   <= '0;
      bus_be_q   <= '0;
      rsp_vld_q  <= 1'b0;
      rdata_q    <= '0;
    end else begin
      st_q       <= st_d;
      cnt_q      <= cnt_d;
      cur_wr_q   <= cur_wr_d;
      cur_cs_q   <= cur_cs_d;
      cur_t_q    <= cur_t_d;
      cur_addr_q <= cur_addr_d;
      cur_wd_q   <= cur_wd_d;
      cur_be_q   <= cur_be_d;
      early_q    <= early_d;
      bus_addr_q <= bus_addr_d;
      bus_wd_q   <= bus_wd_d;
      bus_be_q   <= bus_be_d;
      rsp_vld_q  <= rsp_vld_d;
      rdata_q    <= rdata_d;
    end
  end

  // ---------------- pin decode ----------------
  always_comb begin
    ncs_on    = in_acc && in_window(cur_wr_q ? cur_t_q.ncs_wr : cur_t_q.ncs_rd, cnt_q);
    hold_bus  = in_acc || (in_turn && early_q);
    mem_nwe_n = !(in_acc && cur_wr_q && in_window(cur_t_q.nwe, cnt_q));
    mem_nrd_n = !(in_acc && !cur_wr_q && in_window(cur_t_q.nrd, cnt_q));
    mem_nbs_n = hold_bus ? ~bus_be_q : '1;
    mem_doe   = (in_acc && cur_wr_q) || (in_turn && early_q);
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_ncs
    assign mem_ncs_n[i] = !(ncs_on && (cur_cs_q == SEL_W'(i)));
  end

  assign req_ready = (st_q == ST_IDLE);
  assign mem_addr  = bus_addr_q;
  assign mem_dout  = bus_wd_q;
  assign rsp_valid = rsp_vld_q;
  assign rsp_rdata = rdata_q;

  // ---------------- assertions ----------------
  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_rw_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_nwe_n && !mem_nrd_n));

  p_ncs_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_ncs_n));

  p_rsp_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(in_acc && !cur_wr_q));

  p_turn_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_turn |=> in_acc);

  p_cs_turn_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_turn && !early_q) |-> ((&mem_ncs_n) && mem_nwe_n && mem_nrd_n && !mem_doe));

  p_early_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_turn && early_q) |-> (mem_doe && $stable(mem_addr) && $stable(mem_dout) && (&mem_ncs_n)));

endmodule

// File: rtl/static_mem_seq.sv
module static_mem_seq
  import smseq_pkg::*;
#(
  parameter int unsigned NUM_CS = 4,
  parameter int unsigned AW     = 24,
  parameter int unsigned DW     = 16,
  parameter int unsigned BW     = DW / 8,
  parameter int unsigned SEL_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [SEL_W-1:0]    cfg_sel,
  input  logic [TIMING_W-1:0] cfg_word,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_wr,
  input  logic [SEL_W-1:0]    req_cs,
  input  logic [AW-1:0]       req_addr,
  input  logic [DW-1:0]       req_wdata,
  input  logic [BW-1:0]       req_be,
  output logic                rsp_valid,
  output logic [DW-1:0]       rsp_rdata,
  output logic [AW-1:0]       mem_addr,
  output logic [DW-1:0]       mem_dout,
  output logic                mem_doe,
  input  logic [DW-1:0]       mem_din,
  output logic                mem_nwe_n,
  output logic                mem_nrd_n,
  output logic [NUM_CS-1:0]   mem_ncs_n,
  output logic [BW-1:0]       mem_nbs_n,
  input  logic                mem_nwe_fb
);

  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  cs_timing_t req_tmg;
  turn_e      turn_kind;
  logic       accept;

  smseq_cfg_bank #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (cfg_we),
    .wr_sel  (cfg_sel),
    .wr_word (cs_timing_t'(cfg_word)),
    .rd_sel  (req_cs),
    .rd_word (req_tmg)
  );

  smseq_turn #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_turn (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .accept  (accept),
    .req_wr  (req_wr),
    .req_cs  (req_cs),
    .tmg     (req_tmg),
    .nwe_fb  (mem_nwe_fb),
    .kind    (turn_kind)
  );

  smseq_engine #(.NUM_CS(NUM_CS), .SEL_W(SEL_W), .AW(AW), .DW(DW), .BW(BW)) u_eng (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .accept    (accept),
    .req_wr    (req_wr),
    .req_cs    (req_cs),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_be    (req_be),
    .req_tmg   (req_tmg),
    .turn_kind (turn_kind),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .mem_addr  (mem_addr),
    .mem_dout  (mem_dout),
    .mem_doe   (mem_doe),
    .mem_din   (mem_din),
    .mem_nwe_n (mem_nwe_n),
    .mem_nrd_n (mem_nrd_n),
    .mem_ncs_n (mem_ncs_n),
    .mem_nbs_n (mem_nbs_n)
  );

endmodule

// File: tb/tb_static_mem_seq.sv
`timescale 1ns/1ps
module tb_static_mem_seq;
  import smseq_pkg::*;

  localparam int NCS = 4;
  localparam int AW  = 24;
  localparam int DW  = 16;
  localparam int BW  = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst_n;
  logic            cfg_we;
  logic [1:0]      cfg_sel;
  logic [TIMING_W-1:0] cfg_word;
  logic            req_valid, req_ready, req_wr;
  logic [1:0]      req_cs;
  logic [AW-1:0]   req_addr;
  logic [DW-1:0]   req_wdata;
  logic [BW-1:0]   req_be;
  logic            rsp_valid;
  logic [DW-1:0]   rsp_rdata;
  logic [AW-1:0]   mem_addr;
  logic [DW-1:0]   mem_dout, mem_din;
  logic            mem_doe, mem_nwe_n, mem_nrd_n, mem_nwe_fb;
  logic [NCS-1:0]  mem_ncs_n;
  logic [BW-1:0]   mem_nbs_n;

  static_mem_seq dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_word(cfg_word),
    .req_valid(req_valid), .req_ready(req_ready), .req_wr(req_wr), .req_cs(req_cs),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_dout(mem_dout),
    .mem_doe(mem_doe), .mem_din(mem_din), .mem_nwe_n(mem_nwe_n), .mem_nrd_n(mem_nrd_n),
    .mem_ncs_n(mem_ncs_n), .mem_nbs_n(mem_nbs_n), .mem_nwe_fb(mem_nwe_fb)
  );

  // memory model: valid data only while the read strobe is low
  function automatic logic [DW-1:0] mem_val(logic [AW-1:0] a);
    return a[DW-1:0] ^ 16'h5A3C;
  endfunction
  assign mem_din = mem_nrd_n ? 16'hDEAD : mem_val(mem_addr);

  // write-enable feedback: direct or one clock late
  logic slow_fb;
  logic fb_d1;
  always @(posedge clk) fb_d1 <= mem_nwe_n;
  assign mem_nwe_fb = slow_fb ? fb_d1 : mem_nwe_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard queues
  int    q_busy[$];
  string q_busy_tag[$];
  int    q_wpulse[$];
  int    q_rpulse[$];
  int    q_rdata[$];

  // bench-side model state
  cs_timing_t      cfgm [NCS];
  bit              pv = 0, pw = 0;
  int              pcs = 0;
  logic [AW-1:0]   pw_addr;
  logic [DW-1:0]   pw_data;
  logic [BW-1:0]   pw_be;
  int              cur_cs = 0;
  logic [BW-1:0]   cur_be = '0;
  bit              ncs_seen = 0;

  function automatic cs_timing_t mk(bit m, int wc, int rc, int ws, int wp, int rs, int rp,
                                    int cws, int cwp, int crs, int crp);
    cs_timing_t t;
    t.wr_by_nwe    = m;
    t.wr_cycle     = cnt_t'(wc);
    t.rd_cycle     = cnt_t'(rc);
    t.nwe.setup    = cnt_t'(ws);  t.nwe.pulse    = cnt_t'(wp);
    t.nrd.setup    = cnt_t'(rs);  t.nrd.pulse    = cnt_t'(rp);
    t.ncs_wr.setup = cnt_t'(cws); t.ncs_wr.pulse = cnt_t'(cwp);
    t.ncs_rd.setup = cnt_t'(crs); t.ncs_rd.pulse = cnt_t'(crp);
    return t;
  endfunction

  // 0 = none, 1 = chip select change, 2 = early read
  function automatic int model_turn(bit wr, int cs);
    cs_timing_t t;
    bit nwe_h0, ncs_h0;
    t = cfgm[cs];
    if (!pv) return 0;
    if (pcs != cs) return 1;
    if (!(pw && !wr)) return 0;
    nwe_h0 = (int'(t.nwe.setup) + int'(t.nwe.pulse)) >= int'(t.wr_cycle);
    ncs_h0 = (int'(t.ncs_wr.setup) + int'(t.ncs_wr.pulse)) >= int'(t.wr_cycle);
    if (nwe_h0 && t.nrd.setup == 0) return 2;
    if (!t.wr_by_nwe && ncs_h0 && t.ncs_rd.setup == 0) return 2;
    if (t.wr_by_nwe && nwe_h0 && slow_fb) return 2;
    return 0;
  endfunction

  task automatic load_cfg(int cs, cs_timing_t t);
    @(negedge clk);
    cfg_we   = 1'b1;
    cfg_sel  = 2'(cs);
    cfg_word = t;
    @(negedge clk);
    cfg_we   = 1'b0;
    cfgm[cs] = t;
  endtask

  task automatic access(bit wr, int cs, logic [AW-1:0] a, logic [DW-1:0] d,
                        logic [BW-1:0] be, string tag);
    int turn;
    int cyc;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    turn = model_turn(wr, cs);
    cyc  = wr ? int'(cfgm[cs].wr_cycle) : int'(cfgm[cs].rd_cycle);
    q_busy.push_back(cyc + (turn != 0 ? 1 : 0));
    q_busy_tag.push_back(tag);
    if (wr) q_wpulse.push_back(int'(cfgm[cs].nwe.pulse));
    else begin
      q_rpulse.push_back(int'(cfgm[cs].nrd.pulse));
      q_rdata.push_back(int'(mem_val(a)));
    end
    cur_cs    = cs;
    cur_be    = be;
    ncs_seen  = 0;
    req_valid = 1'b1;
    req_wr    = wr;
    req_cs    = 2'(cs);
    req_addr  = a;
    req_wdata = d;
    req_be    = be;
    @(negedge clk);
    req_valid = 1'b0;
    if (turn == 2) begin
      chk(mem_addr == pw_addr, "R9", "addr held in early cycle", int'(mem_addr), int'(pw_addr));
      chk(mem_doe && mem_dout == pw_data, "R9", "write data held", int'(mem_dout), int'(pw_data));
      chk(mem_nbs_n == ~pw_be, "R9", "byte selects held", int'(mem_nbs_n), int'(~pw_be));
      chk(&mem_ncs_n, "R9", "chip selects high in early cycle", int'(mem_ncs_n), 'hF);
    end else if (turn == 1) begin
      chk((&mem_ncs_n) && mem_nwe_n && mem_nrd_n && !mem_doe, "R5", "quiet turnaround",
          int'({mem_ncs_n, mem_nwe_n, mem_nrd_n, mem_doe}), 'h7E);
    end
    pv  = 1;
    pw  = wr;
    pcs = cs;
    if (wr) begin
      pw_addr = a;
      pw_data = d;
      pw_be   = be;
    end
  endtask

  // monitor: pops expected items as results appear
  int busy_run = 0, wrun = 0, rrun = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (!req_ready) busy_run++;
      else if (busy_run > 0) begin
        if (q_busy.size() > 0) begin
          int e;
          string tg;
          e  = q_busy.pop_front();
          tg = q_busy_tag.pop_front();
          chk(busy_run == e, tg, "busy clocks", busy_run, e);
        end else chk(0, "R1", "unexpected busy period", busy_run, 0);
        busy_run = 0;
      end
      if (!mem_nwe_n) wrun++;
      else if (wrun > 0) begin
        if (q_wpulse.size() > 0) begin
          int e;
          e = q_wpulse.pop_front();
          chk(wrun == e, "R2", "write strobe width", wrun, e);
        end else chk(0, "R2", "unexpected write strobe", wrun, 0);
        wrun = 0;
      end
      if (!mem_nrd_n) rrun++;
      else if (rrun > 0) begin
        if (q_rpulse.size() > 0) begin
          int e;
          e = q_rpulse.pop_front();
          chk(rrun == e, "R2", "read strobe width", rrun, e);
        end else chk(0, "R2", "unexpected read strobe", rrun, 0);
        rrun = 0;
      end
      if (!(&mem_ncs_n) && !ncs_seen) begin
        ncs_seen = 1;
        chk(mem_ncs_n == ~(NCS'(1) << cur_cs), "R3", "chip select line",
            int'(mem_ncs_n), int'(~(NCS'(1) << cur_cs)));
        chk(mem_nbs_n == ~cur_be, "R3", "byte selects", int'(mem_nbs_n), int'(~cur_be));
      end
      if (rsp_valid) begin
        if (q_rdata.size() > 0) begin
          int e;
          e = q_rdata.pop_front();
          chk(int'(rsp_rdata) == e, "R4", "read data", int'(rsp_rdata), e);
        end else chk(0, "R4", "unexpected response", int'(rsp_rdata), 0);
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_word = '0; slow_fb = 1'b0;
    req_valid = 1'b0; req_wr = 1'b0; req_cs = '0; req_addr = '0; req_wdata = '0; req_be = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state (R1, R2, R3)
    chk(req_ready == 1'b1, "R1", "ready in reset", int'(req_ready), 1);
    chk(mem_nwe_n && mem_nrd_n, "R2", "strobes high in reset", int'({mem_nwe_n, mem_nrd_n}), 3);
    chk(&mem_ncs_n, "R3", "chip selects high in reset", int'(mem_ncs_n), 'hF);
    chk(!rsp_valid && !mem_doe, "R4", "no response in reset", int'({rsp_valid, mem_doe}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: timing words per chip select
    load_cfg(0, mk(1, 3, 3, 1, 2, 0, 2, 0, 3, 0, 3));  // strobe rule
    load_cfg(1, mk(0, 4, 4, 1, 1, 1, 2, 0, 4, 0, 4));  // chip-select rule
    load_cfg(2, mk(1, 3, 4, 1, 2, 1, 2, 0, 3, 0, 4));  // feedback rule
    load_cfg(3, mk(0, 3, 3, 1, 1, 0, 2, 0, 2, 0, 3));  // holds present

    access(1, 0, 24'h000010, 16'h1111, 2'b11, "R11");
    access(0, 0, 24'h000010, 16'h0000, 2'b11, "R6");
    access(0, 0, 24'h000014, 16'h0000, 2'b01, "R10");
    access(1, 0, 24'h000018, 16'h2222, 2'b10, "R10");
    access(1, 0, 24'h00001C, 16'h3333, 2'b11, "R10");
    access(0, 1, 24'h000020, 16'h0000, 2'b11, "R5");
    access(1, 1, 24'h000024, 16'h4444, 2'b01, "R10");
    access(0, 1, 24'h000024, 16'h0000, 2'b11, "R7");
    access(1, 2, 24'h000030, 16'h5555, 2'b11, "R5");
    access(0, 2, 24'h000030, 16'h0000, 2'b11, "R8");
    slow_fb = 1'b1;
    access(1, 2, 24'h000034, 16'h6666, 2'b10, "R10");
    access(0, 2, 24'h000034, 16'h0000, 2'b11, "R8");
    slow_fb = 1'b0;
    access(1, 3, 24'h000040, 16'h7777, 2'b11, "R5");
    access(0, 3, 24'h000040, 16'h0000, 2'b11, "R10");
    access(1, 3, 24'h000044, 16'h8888, 2'b01, "R10");
    access(0, 0, 24'h000048, 16'h0000, 2'b11, "R5");

    for (int i = 0; i < 16; i++) begin
      access(((i % 3) == 0), (i * 3) % 4, AW'(24'h000100 + i * 4), DW'(16'hA000 + i),
             BW'(i % 3 + 1), "R1");
    end

    repeat (12) @(negedge clk);
    chk(q_busy.size() == 0 && q_rdata.size() == 0, "R1", "scoreboard drained",
        q_busy.size() + q_rdata.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule